// File: doc/BRIEF.md
# Cable Connect Debounce and Port Enable Control

This block watches a single cable port's raw connection indication, which goes high when the remote end's bias voltage is present. It turns that indication into a clean link status. A new connection is reported only after the indication has stayed high for a programmable number of clock cycles. A loss of connection is reported straight away, and each connection that survives the full settling window produces a one-cycle request to start a bus reset.

The link status is combined with a power-down input, an active-low port reset and two internal blocking signals, one for transmit and one for receive. From these the block drives three enables: one for the line transmitter, one for the line receiver and one for the bias-voltage source. The port reset is sampled synchronously. While it is low, the link is held down and the settling count is cleared.

Top module: `cable_connect_ctrl`

## Requirements
- R1: After `cable_bias_raw` rises and stays high, `link_up` rises exactly SYNC_STAGES + DEBOUNCE_CYCLES clock edges after the first edge that samples the high level. With the defaults (2 and 16), that is the 18th edge.
- R2: When `cable_bias_raw` falls, `link_up` drops after exactly SYNC_STAGES edges, with no settling delay.
- R3: `bus_reset_req` is high for exactly one cycle, in the cycle in which `link_up` rises. It stays low for as long as the link remains up.
- R4: `cable_inactive` is always the inverse of `link_up`.
- R5: `tx_enable` is 1 only when `power_down` is 0, `cable_inactive` is 0, `port_reset_n` is 1 and `tx_disable` is 0.
- R6: `rx_enable` is 1 only when `power_down` is 0, `cable_inactive` is 0 and `rx_disable` is 0. The port reset does not enter this enable directly.
- R7: `bias_enable` is 0 only when `power_down` is 1 or `port_reset_n` is 0. Power-down does not affect the link status.
- R8: If the synchronized raw level goes low at any point during the settling window, the count restarts. A full DEBOUNCE_CYCLES run of high samples is then needed after the level returns.
- R9: A low `port_reset_n` takes priority over a settling count that is completing in the same cycle. In that case neither `link_up` nor `bus_reset_req` rises. After release, the full R1 latency applies again.
- R10: While `port_reset_n` is low, `link_up`, `bus_reset_req`, `tx_enable`, `rx_enable` and `bias_enable` are 0 and `cable_inactive` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| port_reset_n | input | 1 | Active-low port reset, sampled synchronously |
| power_down | input | 1 | Power-down request, active high |
| tx_disable | input | 1 | Internal transmit block, active high |
| rx_disable | input | 1 | Internal receive block, active high |
| cable_bias_raw | input | 1 | Asynchronous raw remote-bias presence |
| link_up | output | 1 | Debounced cable connection status |
| cable_inactive | output | 1 | High when no cable is reported connected |
| bus_reset_req | output | 1 | One-cycle bus-reset request on completed connect |
| tx_enable | output | 1 | Line transmitter enable |
| rx_enable | output | 1 | Line receiver enable |
| bias_enable | output | 1 | Bias-voltage source enable |

## Verification
Two events can land on the same clock edge: the settling count reaching its last sample and a port reset being asserted. To force this, the bench holds the raw level high and lowers `port_reset_n` exactly in the cycle in which the connect would complete. The expected outcome is that neither `link_up` nor `bus_reset_req` appears. After release, the bench checks that the link comes up with a fresh pulse only after the full latency has elapsed again.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    typedef enum logic [1:0] {
        LNK_DOWN   = 2'd0,
        LNK_SETTLE = 2'd1,
        LNK_UP     = 2'd2
    } link_state_e;

    // Enable bundle sent to the analog port
    typedef struct packed {
        logic tx;
        logic rx;
        logic bias;
    } port_en_t;

    // Conditions that may block the enables
    typedef struct packed {
        logic power_down;
        logic reset_n;
        logic tx_block;
        logic rx_block;
        logic inactive;
    } en_ctl_t;

    function automatic port_en_t gate_enables(en_ctl_t c);
        port_en_t e;
        e.tx   = !c.power_down && c.reset_n && !c.inactive && !c.tx_block;
        e.rx   = !c.power_down && !c.inactive && !c.rx_block;
        e.bias = !c.power_down && c.reset_n;
        return e;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cdb_sync.sv
module cdb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cdb_debounce.sv
module cdb_debounce
    import cdb_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic link,
    output logic pulse
);
    localparam int unsigned CW = cnt_width(DEBOUNCE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

    link_state_e   state_q;
    logic [CW-1:0] cnt_q;
    logic          pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LNK_DOWN;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (!level) begin
                // dropout: immediate down, window restarts
                state_q <= LNK_DOWN;
                cnt_q   <= '0;
            end else if (state_q != LNK_UP) begin
                if (cnt_q == LAST) begin
                    state_q <= LNK_UP;
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    state_q <= LNK_SETTLE;
                    cnt_q   <= cnt_q + 1'b1;
                end
            end
        end
    end

    // A fall of the synchronized level clears the link in the same cycle
    assign link  = (state_q == LNK_UP) && level && rst_n;
    assign pulse = pulse_q && link;
endmodule

// File: rtl/cdb_enables.sv
module cdb_enables
    import cdb_pkg::*;
(
    input  en_ctl_t  ctl,
    output port_en_t en
);
    always_comb en = gate_enables(ctl);
endmodule

// File: rtl/cable_connect_ctrl.sv
module cable_connect_ctrl
    import cdb_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = 16,
    parameter int unsigned SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic port_reset_n,
    input  logic power_down,
    input  logic tx_disable,
    input  logic rx_disable,
    input  logic cable_bias_raw,
    output logic link_up,
    output logic cable_inactive,
    output logic bus_reset_req,
    output logic tx_enable,
    output logic rx_enable,
    output logic bias_enable
);
    logic     sync_level;
    en_ctl_t  ctl;
    port_en_t en;

    cdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (port_reset_n),
        .d     (cable_bias_raw),
        .q     (sync_level)
    );

    cdb_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk   (clk),
        .rst_n (port_reset_n),
        .level (sync_level),
        .link  (link_up),
        .pulse (bus_reset_req)
    );

    assign cable_inactive = !link_up;

    always_comb begin
        ctl.power_down = power_down;
        ctl.reset_n    = port_reset_n;
        ctl.tx_block   = tx_disable;
        ctl.rx_block   = rx_disable;
        ctl.inactive   = cable_inactive;
    end

    cdb_enables u_en (
        .ctl (ctl),
        .en  (en)
    );

    assign tx_enable   = en.tx;
    assign rx_enable   = en.rx;
    assign bias_enable = en.bias;
endmodule

// File: rtl/cable_connect_ctrl_chk.sv
module cable_connect_ctrl_chk #(
    parameter int unsigned DEBOUNCE_CYCLES = 16
) (
    input logic clk,
    input logic port_reset_n,
    input logic sync_level,
    input logic link_up,
    input logic bus_reset_req
);
    localparam int unsigned RW = $clog2(DEBOUNCE_CYCLES + 2);

    // run length of consecutive high synchronized samples, saturating
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!port_reset_n || !sync_level) run_q <= '0;
        else if (run_q != RW'(DEBOUNCE_CYCLES + 1)) run_q <= run_q + 1'b1;
    end

    p_settle_len_r1: assert property (@(posedge clk) disable iff (!port_reset_n)
        $rose(link_up) |-> (run_q >= RW'(DEBOUNCE_CYCLES)));

    p_drop_fast_r2: assert property (@(posedge clk) disable iff (!port_reset_n)
        !sync_level |=> !link_up);

    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!port_reset_n)
        bus_reset_req |=> !bus_reset_req);

    p_pulse_on_rise_r3: assert property (@(posedge clk) disable iff (!port_reset_n)
        $rose(link_up) |-> bus_reset_req);

    p_pulse_needs_link_r3: assert property (@(posedge clk) disable iff (!port_reset_n)
        bus_reset_req |-> link_up);

    p_restart_r8: assert property (@(posedge clk) disable iff (!port_reset_n)
        (!link_up && !sync_level) |=> !link_up);
endmodule

bind cable_connect_ctrl cable_connect_ctrl_chk #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_chk (
    .clk           (clk),
    .port_reset_n  (port_reset_n),
    .sync_level    (sync_level),
    .link_up       (link_up),
    .bus_reset_req (bus_reset_req)
);

// File: tb/test_cable_connect_ctrl.sv
`timescale 1ns/1ps
module test_cable_connect_ctrl;
    localparam int unsigned DB = 16;

    typedef struct {
        bit    conn;
        bit    brst;
        bit    tx;
        bit    rx;
        bit    bias;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic port_reset_n = 1'b0;
    logic power_down = 1'b0;
    logic tx_disable = 1'b0;
    logic rx_disable = 1'b0;
    logic cable_bias_raw = 1'b0;
    logic link_up, cable_inactive, bus_reset_req, tx_enable, rx_enable, bias_enable;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    cable_connect_ctrl #(.DEBOUNCE_CYCLES(DB), .SYNC_STAGES(2)) i_cable_connect_ctrl (
        .clk            (clk),
        .port_reset_n   (port_reset_n),
        .power_down     (power_down),
        .tx_disable     (tx_disable),
        .rx_disable     (rx_disable),
        .cable_bias_raw (cable_bias_raw),
        .link_up        (link_up),
        .cable_inactive (cable_inactive),
        .bus_reset_req  (bus_reset_req),
        .tx_enable      (tx_enable),
        .rx_enable      (rx_enable),
        .bias_enable    (bias_enable)
    );

    task automatic cmp(input bit act, input bit exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // driver: one cycle of stimulus, expectation pushed for the next edge
    task automatic st(input bit raw, input bit pd, input bit rn, input bit txd, input bit rxd,
                      input bit ec, input bit eb, input string tag);
        exp_t e;
        @(negedge clk);
        cable_bias_raw = raw;
        power_down     = pd;
        port_reset_n   = rn;
        tx_disable     = txd;
        rx_disable     = rxd;
        e.conn = ec;
        e.brst = eb;
        e.tx   = !pd && ec && rn && !txd;
        e.rx   = !pd && ec && !rxd;
        e.bias = !pd && rn;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // monitor: compares results 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(link_up, e.conn, e.tag, "link_up");
                cmp(bus_reset_req, e.brst, e.tag, "bus_reset_req");
                cmp(cable_inactive, !e.conn, "R4", "cable_inactive");
                cmp(tx_enable, e.tx, "R5", "tx_enable");
                cmp(rx_enable, e.rx, "R6", "rx_enable");
                cmp(bias_enable, e.bias, "R7", "bias_enable");
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: port reset state
        repeat (3) st(0, 0, 0, 0, 0, 0, 0, "R10");
        repeat (2) st(0, 0, 1, 0, 0, 0, 0, "R10");

        // R1 connect latency, R3 single pulse
        for (int k = 1; k <= DB + 1; k++) st(1, 0, 1, 0, 0, 0, 0, "R1");
        st(1, 0, 1, 0, 0, 1, 1, "R3");
        repeat (5) st(1, 0, 1, 0, 0, 1, 0, "R3");

        // enable gating with the link up
        st(1, 1, 1, 0, 0, 1, 0, "R7");
        st(1, 0, 1, 1, 0, 1, 0, "R5");
        st(1, 0, 1, 0, 1, 1, 0, "R6");
        st(1, 0, 1, 1, 1, 1, 0, "R6");
        st(1, 0, 1, 0, 0, 1, 0, "R5");

        // R2 immediate disconnect
        st(0, 0, 1, 0, 0, 1, 0, "R2");
        st(0, 0, 1, 0, 0, 0, 0, "R2");
        repeat (2) st(0, 0, 1, 0, 0, 0, 0, "R4");

        // R8 dropout in the settling window restarts the count
        repeat (10) st(1, 0, 1, 0, 0, 0, 0, "R8");
        st(0, 0, 1, 0, 0, 0, 0, "R8");
        for (int k = 1; k <= DB + 1; k++) st(1, 0, 1, 0, 0, 0, 0, "R8");
        st(1, 0, 1, 0, 0, 1, 1, "R8");
        st(1, 0, 1, 0, 0, 1, 0, "R3");
        st(0, 0, 1, 0, 0, 1, 0, "R2");
        repeat (3) st(0, 0, 1, 0, 0, 0, 0, "R2");

        // R9 reset lands on the completing edge
        for (int k = 1; k <= DB + 1; k++) st(1, 0, 1, 0, 0, 0, 0, "R9");
        st(1, 0, 0, 0, 0, 0, 0, "R9");
        for (int k = 1; k <= DB + 1; k++) st(1, 0, 1, 0, 0, 0, 0, "R9");
        st(1, 0, 1, 0, 0, 1, 1, "R9");
        st(1, 0, 1, 0, 0, 1, 0, "R9");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule